// File: doc/BRIEF.md
# Early Read Request Detector

This block lives in the system-side logic next to a processor that shares its command and address/data buses with a secondary cache controller. It watches the processor's command bus and valid strobe, the cache controller's tag-operation flags and its tag hit line. It decides, ahead of the controller, whether a read will have to be served by system memory. When it will, the block raises a one-cycle start pulse at once, rather than waiting for the controller's forwarded valid strobe.

Uncacheable (partial) reads are started in the cycle after the processor first raises its valid strobe, provided the controller reports no tag operation. Cacheable (block) reads wait one lookup cycle. There, a tag hit means the secondary cache supplies the data and nothing happens, while a miss starts the request at once. Since the controller still forwards the request later, the block remembers that it started early and swallows exactly one forwarded strobe. A forwarded strobe with no early start behind it is served as an ordinary request. The bus-drive enable for the shared buses rises only after the controller's release strobe has been sampled. It falls when the system's data path reports the request complete.

Top module: `early_read_detect`

## Requirements
- R1: After a synchronous reset, `start_pulse` and `drive_en` are both low.
- R2: A partial read is the command with bits [7:5] equal to 000 and bit 3 equal to 1. In the first cycle that `cmd_valid` is high with a partial read and both `tag_op_a` and `tag_op_b` low, `start_pulse` is high in the next cycle, and for that cycle only.
- R3: A partial read that arrives with `tag_op_a` or `tag_op_b` high produces no early start.
- R4: A block read is the command with bits [7:5] equal to 000 and bit 3 equal to 0. `lookup_hit` is sampled in the cycle after the first `cmd_valid` cycle. If it is high, no start pulse follows.
- R5: If `lookup_hit` is low in that lookup cycle, `start_pulse` is high in the cycle after the lookup cycle.
- R6: After an early start, the next `fwd_valid` pulse produces no start pulse. This holds whether it arrives while the request is open or after `resp_done` has closed it.
- R7: A `fwd_valid` pulse with no early start pending, while idle, makes `start_pulse` and `drive_en` high together in the next cycle.
- R8: For an early-started request, `drive_en` stays low until `bus_release` is sampled high while the request is open, and is high from the next cycle. When no request is open, `bus_release` has no effect.
- R9: `resp_done` sampled high while a request is open makes `drive_en` low in the next cycle and closes the request.
- R10: Only the first cycle of a `cmd_valid` assertion can start a request, and a command with any of bits [7:5] set starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_bus | input | CMD_W | Processor command bus |
| cmd_valid | input | 1 | Processor command valid strobe, active high |
| tag_op_a | input | 1 | Cache controller tag-operation flag, first |
| tag_op_b | input | 1 | Cache controller tag-operation flag, second |
| lookup_hit | input | 1 | Tag lookup hit from the cache controller |
| fwd_valid | input | 1 | Request forwarded by the cache controller, one-cycle pulse |
| bus_release | input | 1 | Cache controller has released the shared buses |
| resp_done | input | 1 | System data path has finished the open request |
| start_pulse | output | 1 | One-cycle pulse: begin servicing a read |
| drive_en | output | 1 | System may drive the command and address/data buses |

## Verification
Suppose the early-start pending flag were lost or stuck. A lost flag shows up as a second `start_pulse` one cycle after the forwarded strobe. A stuck flag makes a genuine forwarded request produce no pulse at all. A controller left in the lookup state, or hit and miss read the wrong way round, is visible on `start_pulse` two cycles after the first valid cycle. A release-gating fault shows up on `drive_en` one cycle after the stimulus: the enable either rises before `bus_release` or survives `resp_done`.

// File: rtl/erd_pkg.sv
package erd_pkg;
  // Field positions in the processor command that the decode depends on
  localparam int unsigned OP_HI  = 7;
  localparam int unsigned OP_LO  = 5;
  localparam int unsigned RD_BIT = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_ACTIVE = 2'd2
  } erd_state_e;
endpackage

// File: rtl/erd_decode.sv
module erd_decode
  import erd_pkg::*;
#(
  parameter int unsigned CMD_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd_bus,
  input  logic             cmd_valid,
  output logic             req_first,
  output logic             is_partial,
  output logic             is_block
);
  localparam int unsigned OP_W = OP_HI - OP_LO + 1;

  logic valid_q;
  logic read_class;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= cmd_valid;
  end

  always_comb begin
    read_class = (cmd_bus[OP_HI:OP_LO] == OP_W'(0));
    req_first  = cmd_valid & ~valid_q;
    is_partial = read_class &  cmd_bus[RD_BIT];
    is_block   = read_class & ~cmd_bus[RD_BIT];
  end
endmodule

// File: rtl/erd_ctrl.sv
module erd_ctrl
  import erd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_first,
  input  logic is_partial,
  input  logic is_block,
  input  logic tag_op_a,
  input  logic tag_op_b,
  input  logic lookup_hit,
  input  logic fwd_valid,
  input  logic resp_done,
  output logic arm_early,
  output logic arm_fwd,
  output logic in_idle,
  output logic in_lookup,
  output logic in_active,
  output logic pending,
  output logic start_pulse
);
  erd_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       start_q;
  logic       tag_busy;
  logic       swallow;

  assign tag_busy = tag_op_a | tag_op_b;
  assign swallow  = fwd_valid & pend_q;

  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    arm_early = 1'b0;
    arm_fwd   = 1'b0;
    if (swallow) pend_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_first && is_partial && !tag_busy) begin
          arm_early = 1'b1;
          pend_d    = 1'b1;
          state_d   = ST_ACTIVE;
        end else if (req_first && is_block) begin
          state_d = ST_LOOKUP;
        end else if (fwd_valid && !pend_q) begin
          arm_fwd = 1'b1;
          state_d = ST_ACTIVE;
        end
      end
      ST_LOOKUP: begin
        if (lookup_hit) begin
          state_d = ST_IDLE;
        end else begin
          arm_early = 1'b1;
          pend_d    = 1'b1;
          state_d   = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (resp_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      start_q <= arm_early | arm_fwd;
    end
  end

  assign in_idle     = (state_q == ST_IDLE);
  assign in_lookup   = (state_q == ST_LOOKUP);
  assign in_active   = (state_q == ST_ACTIVE);
  assign pending     = pend_q;
  assign start_pulse = start_q;
endmodule

// File: rtl/erd_drive.sv
module erd_drive (
  input  logic clk,
  input  logic rst,
  input  logic arm_early,
  input  logic arm_fwd,
  input  logic in_active,
  input  logic bus_release,
  input  logic resp_done,
  output logic drive_en
);
  logic drive_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
    end else if (in_active && resp_done) begin
      drive_q <= 1'b0;
    end else if (arm_fwd) begin
      // the controller forwards only after it has let go of the buses
      drive_q <= 1'b1;
    end else if ((in_active || arm_early) && bus_release) begin
      drive_q <= 1'b1;
    end else if (!in_active && !arm_early) begin
      drive_q <= 1'b0;
    end
  end

  assign drive_en = drive_q;
endmodule

// File: rtl/early_read_detect.sv
module early_read_detect #(
  parameter int unsigned CMD_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd_bus,
  input  logic             cmd_valid,
  input  logic             tag_op_a,
  input  logic             tag_op_b,
  input  logic             lookup_hit,
  input  logic             fwd_valid,
  input  logic             bus_release,
  input  logic             resp_done,
  output logic             start_pulse,
  output logic             drive_en
);
  logic req_first, is_partial, is_block;
  logic arm_early, arm_fwd;
  logic in_idle, in_lookup, in_active, pending;

  erd_decode #(.CMD_W(CMD_W)) u_decode (
    .clk        (clk),
    .rst        (rst),
    .cmd_bus    (cmd_bus),
    .cmd_valid  (cmd_valid),
    .req_first  (req_first),
    .is_partial (is_partial),
    .is_block   (is_block)
  );

  erd_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_first   (req_first),
    .is_partial  (is_partial),
    .is_block    (is_block),
    .tag_op_a    (tag_op_a),
    .tag_op_b    (tag_op_b),
    .lookup_hit  (lookup_hit),
    .fwd_valid   (fwd_valid),
    .resp_done   (resp_done),
    .arm_early   (arm_early),
    .arm_fwd     (arm_fwd),
    .in_idle     (in_idle),
    .in_lookup   (in_lookup),
    .in_active   (in_active),
    .pending     (pending),
    .start_pulse (start_pulse)
  );

  erd_drive u_drive (
    .clk         (clk),
    .rst         (rst),
    .arm_early   (arm_early),
    .arm_fwd     (arm_fwd),
    .in_active   (in_active),
    .bus_release (bus_release),
    .resp_done   (resp_done),
    .drive_en    (drive_en)
  );
endmodule

// File: rtl/erd_checker.sv
module erd_checker (
  input logic clk,
  input logic rst,
  input logic req_first,
  input logic is_partial,
  input logic tag_op_a,
  input logic tag_op_b,
  input logic lookup_hit,
  input logic fwd_valid,
  input logic bus_release,
  input logic resp_done,
  input logic in_idle,
  input logic in_lookup,
  input logic in_active,
  input logic pending,
  input logic start_pulse,
  input logic drive_en
);
  p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);

  p_tag_busy_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (in_idle && req_first && is_partial && (tag_op_a || tag_op_b) && !fwd_valid)
      |=> !start_pulse);

  p_hit_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (in_lookup && lookup_hit) |=> !start_pulse);

  p_miss_start_r5: assert property (@(posedge clk) disable iff (rst)
    (in_lookup && !lookup_hit) |=> start_pulse);

  p_swallow_r6: assert property (@(posedge clk) disable iff (rst)
    (in_active && pending && fwd_valid) |=> !start_pulse);

  p_drive_gate_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_en) |-> ($past(bus_release) || start_pulse));

  p_done_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (in_active && resp_done) |=> !drive_en);
endmodule

bind early_read_detect erd_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_first   (req_first),
  .is_partial  (is_partial),
  .tag_op_a    (tag_op_a),
  .tag_op_b    (tag_op_b),
  .lookup_hit  (lookup_hit),
  .fwd_valid   (fwd_valid),
  .bus_release (bus_release),
  .resp_done   (resp_done),
  .in_idle     (in_idle),
  .in_lookup   (in_lookup),
  .in_active   (in_active),
  .pending     (pending),
  .start_pulse (start_pulse),
  .drive_en    (drive_en)
);

// File: tb/tb_early_read_detect.sv
`timescale 1ns/1ps
module tb_early_read_detect;
  localparam int CMD_W = 9;
  localparam logic [CMD_W-1:0] CMD_PARTIAL = 9'h008;
  localparam logic [CMD_W-1:0] CMD_BLOCK   = 9'h000;
  localparam logic [CMD_W-1:0] CMD_OTHER   = 9'h048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CMD_W-1:0] cmd_bus = '0;
  logic cmd_valid = 1'b0, tag_op_a = 1'b0, tag_op_b = 1'b0, lookup_hit = 1'b0;
  logic fwd_valid = 1'b0, bus_release = 1'b0, resp_done = 1'b0;
  logic start_pulse, drive_en;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  early_read_detect #(.CMD_W(CMD_W)) dut (
    .clk(clk), .rst(rst), .cmd_bus(cmd_bus), .cmd_valid(cmd_valid),
    .tag_op_a(tag_op_a), .tag_op_b(tag_op_b), .lookup_hit(lookup_hit),
    .fwd_valid(fwd_valid), .bus_release(bus_release), .resp_done(resp_done),
    .start_pulse(start_pulse), .drive_en(drive_en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic close_req();
    resp_done = 1'b1; tick(); resp_done = 1'b0;
    chk("R9 drive cleared by done", drive_en, 1'b0);
    tick();
  endtask

  task automatic t_reset();
    chk("R1 start low after reset", start_pulse, 1'b0);
    chk("R1 drive low after reset", drive_en, 1'b0);
  endtask

  task automatic t_partial_early();
    cmd_bus = CMD_PARTIAL; cmd_valid = 1'b1; tick(); cmd_valid = 1'b0;
    chk("R2 partial early start", start_pulse, 1'b1);
    chk("R8 no drive before release", drive_en, 1'b0);
    tick();
    chk("R2 start lasts one cycle", start_pulse, 1'b0);
    fwd_valid = 1'b1; tick(); fwd_valid = 1'b0;
    chk("R6 forwarded strobe swallowed", start_pulse, 1'b0);
    chk("R8 still no drive", drive_en, 1'b0);
    bus_release = 1'b1; tick(); bus_release = 1'b0;
    chk("R8 drive after release", drive_en, 1'b1);
    close_req();
  endtask

  task automatic t_partial_held();
    cmd_bus = CMD_PARTIAL; cmd_valid = 1'b1; tick();
    chk("R10 first valid cycle starts", start_pulse, 1'b1);
    tick();
    chk("R10 held valid no restart", start_pulse, 1'b0);
    tick();
    chk("R10 held valid no restart", start_pulse, 1'b0);
    cmd_valid = 1'b0;
    fwd_valid = 1'b1; tick(); fwd_valid = 1'b0;
    chk("R6 swallow after held valid", start_pulse, 1'b0);
    bus_release = 1'b1; tick(); bus_release = 1'b0;
    close_req();
  endtask

  task automatic t_block_miss();
    cmd_bus = CMD_BLOCK; cmd_valid = 1'b1; tick(); cmd_valid = 1'b0;
    lookup_hit = 1'b0;
    chk("R5 no start during lookup", start_pulse, 1'b0);
    tick();
    chk("R5 miss starts after lookup", start_pulse, 1'b1);
    tick();
    fwd_valid = 1'b1; tick(); fwd_valid = 1'b0;
    chk("R6 miss forward swallowed", start_pulse, 1'b0);
    bus_release = 1'b1; tick(); bus_release = 1'b0;
    chk("R8 drive after release on miss", drive_en, 1'b1);
    close_req();
  endtask

  task automatic t_block_hit();
    cmd_bus = CMD_BLOCK; cmd_valid = 1'b1; tick(); cmd_valid = 1'b0;
    lookup_hit = 1'b1; tick(); lookup_hit = 1'b0;
    chk("R4 hit gives no start", start_pulse, 1'b0);
    tick();
    chk("R4 hit still quiet", start_pulse, 1'b0);
    bus_release = 1'b1; tick(); bus_release = 1'b0;
    chk("R8 release ignored when idle", drive_en, 1'b0);
    tick();
  endtask

  task automatic t_tag_busy(input bit use_b);
    cmd_bus = CMD_PARTIAL; cmd_valid = 1'b1;
    tag_op_a = !use_b; tag_op_b = use_b;
    tick(); cmd_valid = 1'b0; tag_op_a = 1'b0; tag_op_b = 1'b0;
    chk("R3 tag op blocks early start", start_pulse, 1'b0);
    tick();
    chk("R3 still no start", start_pulse, 1'b0);
    fwd_valid = 1'b1; tick(); fwd_valid = 1'b0;
    chk("R7 forwarded request starts", start_pulse, 1'b1);
    chk("R7 drive with forwarded start", drive_en, 1'b1);
    close_req();
  endtask

  task automatic t_other_cmd();
    cmd_bus = CMD_OTHER; cmd_valid = 1'b1; tick(); cmd_valid = 1'b0;
    chk("R10 non-read ignored", start_pulse, 1'b0);
    tick();
    chk("R10 non-read ignored later", start_pulse, 1'b0);
    chk("R10 no drive for non-read", drive_en, 1'b0);
  endtask

  task automatic t_late_forward();
    cmd_bus = CMD_PARTIAL; cmd_valid = 1'b1; tick(); cmd_valid = 1'b0;
    chk("R2 start before early close", start_pulse, 1'b1);
    resp_done = 1'b1; tick(); resp_done = 1'b0;
    tick();
    fwd_valid = 1'b1; tick(); fwd_valid = 1'b0;
    chk("R6 late forward swallowed while idle", start_pulse, 1'b0);
    chk("R8 no drive from late forward", drive_en, 1'b0);
    tick();
    fwd_valid = 1'b1; tick(); fwd_valid = 1'b0;
    chk("R7 fresh forward starts", start_pulse, 1'b1);
    close_req();
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_partial_early();
    t_partial_held();
    t_block_miss();
    t_block_hit();
    t_tag_busy(1'b0);
    t_tag_busy(1'b1);
    t_other_cmd();
    t_late_forward();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule